// File: doc/BRIEF.md
# Coherent Time Counter Register Pair

This block keeps a 64-bit running time value that software reaches through 32-bit registers. The value advances by one on each cycle in which the `tick` input is high. An external prescaler supplies that input, and it is not part of this block. Software can read the counter at any time while it runs. A read of the low word returns the live bits. The same read also captures the high word into a shadow register, so a later read of the high word gives a value that matches the low word read before it.

To set the time, software writes the low and high staging words in either order. The counter does not change when a staging word is written. Software then writes 1 to the upload bit of the control register. One cycle later, all 64 staged bits replace the counter together, and the upload bit clears itself. If a tick arrives in that same cycle, the upload takes priority and the tick is dropped.

Top module: `coherentTimeCounter`

## Requirements
- R1: After reset, the counter, both staging words, the shadow word and the upload bit are all 0, and every read returns 0.
- R2: In a cycle with no pending upload, `tick` high adds exactly 1 to the counter and `tick` low leaves it unchanged.
- R3: The counter wraps from all ones (64 bits) to zero on a tick.
- R4: A write to offset 0x20 (staging bits 31:0) or offset 0x24 (staging bits 63:32) leaves the counter unchanged.
- R5: A write to offset 0x28 with bit 0 set raises the upload bit, which reads back as bit 0 at 0x28. At the next clock edge the counter takes all 64 staged bits and the upload bit returns to 0 unless that same cycle writes it to 1 again.
- R6: When the upload bit is set and `tick` is high in the same cycle, the counter takes the staged value and the tick is not counted.
- R7: A read at offset 0x20 returns counter bits 31:0 in the same cycle, and at that clock edge copies counter bits 63:32 into the shadow word.
- R8: A read at offset 0x24 returns the shadow word, which is the value of counter bits 63:32 at the last read of 0x20, or 0 if there has been none since reset, even after the counter has moved on.
- R9: A read of any other offset returns 0, `rdData` is 0 whenever `rdEn` is low, and writes to other offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable pulse from the prescaler |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe; returns data in the same cycle |
| addr | input | 8 | Byte offset of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, combinational from the current state |

## Verification
The counter is driven with dense random ticks, with sparse ticks, and with ticks held low. This separates correct increments from dropped or doubled counts. Reads of the high word come both directly after a low read and many cycles after it, with ticks in between and with counts that cross a word boundary. This shows whether the high word comes from the shadow or from the live counter. Uploads are issued with and without a tick in the same cycle, and also right after a staging write. This separates the upload-wins rule and the one-cycle delay of the staging registers from a direct write into the counter. A load near all ones followed by ticks exercises the wrap.

// File: rtl/tcPkg.sv
package tcPkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HI   = 2'd2,
    SEL_CTRL = 2'd3
  } tcRdSel_e;

  typedef struct packed {
    logic [1:0] wrHalf;
    logic       upload;
    logic       captureHi;
  } tcStrobes_t;
endpackage

// File: rtl/tcControl.sv
module tcControl
  import tcPkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter logic [ADDR_W-1:0] LO_OFS   = 'h20,
  parameter logic [ADDR_W-1:0] HI_OFS   = 'h24,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 'h28
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output tcStrobes_t        strobes,
  output tcRdSel_e          rdSel,
  output logic              uploadBit
);
  logic hitLo, hitHi, hitCtrl;
  logic uploadQ;

  assign hitLo   = (addr == LO_OFS);
  assign hitHi   = (addr == HI_OFS);
  assign hitCtrl = (addr == CTRL_OFS);

  // Upload bit lives one cycle and then clears unless rewritten.
  always_ff @(posedge clk) begin
    if (!rstN) uploadQ <= 1'b0;
    else       uploadQ <= wrEn && hitCtrl && wrData[0];
  end

  always_comb begin
    strobes.wrHalf[0] = wrEn && hitLo;
    strobes.wrHalf[1] = wrEn && hitHi;
    strobes.upload    = uploadQ;
    strobes.captureHi = rdEn && hitLo;
  end

  always_comb begin
    rdSel = SEL_NONE;
    if (rdEn) begin
      if (hitLo)        rdSel = SEL_LO;
      else if (hitHi)   rdSel = SEL_HI;
      else if (hitCtrl) rdSel = SEL_CTRL;
    end
  end

  assign uploadBit = uploadQ;
endmodule

// File: rtl/tcDatapath.sv
module tcDatapath
  import tcPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  tick,
  input  logic [DATA_W-1:0]     wrData,
  input  tcStrobes_t            strobes,
  input  tcRdSel_e              rdSel,
  input  logic                  uploadBit,
  output logic [DATA_W-1:0]     rdData,
  output logic [2*DATA_W-1:0]   cntNow,
  output logic [2*DATA_W-1:0]   stageNow,
  output logic [DATA_W-1:0]     shadowNow
);
  localparam int HALVES = 2;
  localparam int CNT_W  = HALVES * DATA_W;

  logic [CNT_W-1:0]  cntQ;
  logic [CNT_W-1:0]  stageQ;
  logic [DATA_W-1:0] shadowQ;

  for (genvar h = 0; h < HALVES; h++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rstN)                 stageQ[h*DATA_W +: DATA_W] <= '0;
      else if (strobes.wrHalf[h]) stageQ[h*DATA_W +: DATA_W] <= wrData;
    end
  end

  // Upload takes priority over a coincident tick.
  always_ff @(posedge clk) begin
    if (!rstN)               cntQ <= '0;
    else if (strobes.upload) cntQ <= stageQ;
    else if (tick)           cntQ <= cntQ + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  shadowQ <= '0;
    else if (strobes.captureHi) shadowQ <= cntQ[CNT_W-1 -: DATA_W];
  end

  always_comb begin
    unique case (rdSel)
      SEL_LO:   rdData = cntQ[DATA_W-1:0];
      SEL_HI:   rdData = shadowQ;
      SEL_CTRL: rdData = {{(DATA_W-1){1'b0}}, uploadBit};
      default:  rdData = '0;
    endcase
  end

  assign cntNow    = cntQ;
  assign stageNow  = stageQ;
  assign shadowNow = shadowQ;
endmodule

// File: rtl/coherentTimeCounter.sv
module coherentTimeCounter
  import tcPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] LO_OFS   = 'h20,
  parameter logic [ADDR_W-1:0] HI_OFS   = 'h24,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 'h28
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam int CNT_W = 2 * DATA_W;

  tcStrobes_t        strobes;
  tcRdSel_e          rdSel;
  logic              uploadNow;
  logic [CNT_W-1:0]  cntNow;
  logic [CNT_W-1:0]  stageNow;
  logic [DATA_W-1:0] shadowNow;

  tcControl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .LO_OFS(LO_OFS), .HI_OFS(HI_OFS), .CTRL_OFS(CTRL_OFS)
  ) uCtl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .strobes(strobes), .rdSel(rdSel), .uploadBit(uploadNow)
  );

  tcDatapath #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .tick(tick), .wrData(wrData),
    .strobes(strobes), .rdSel(rdSel), .uploadBit(uploadNow),
    .rdData(rdData), .cntNow(cntNow), .stageNow(stageNow),
    .shadowNow(shadowNow)
  );
endmodule

// File: rtl/tcChecker.sv
module tcChecker #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] LO_OFS = 'h20,
  parameter logic [ADDR_W-1:0] HI_OFS = 'h24
) (
  input logic                clk,
  input logic                rstN,
  input logic                tick,
  input logic                wrEn,
  input logic                rdEn,
  input logic [ADDR_W-1:0]   addr,
  input logic [DATA_W-1:0]   rdData,
  input logic                uploadNow,
  input logic [2*DATA_W-1:0] cntNow,
  input logic [2*DATA_W-1:0] stageNow,
  input logic [DATA_W-1:0]   shadowNow
);
  p_inc_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!uploadNow && tick) |=> cntNow == $past(cntNow) + 1'b1);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!uploadNow && !tick) |=> $stable(cntNow));

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!uploadNow && tick && (&cntNow)) |=> cntNow == '0);

  p_self_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (uploadNow && !wrEn) |=> !uploadNow);

  p_upload_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
    uploadNow |=> cntNow == $past(stageNow));

  p_lo_live_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == LO_OFS) |-> rdData == cntNow[DATA_W-1:0]);

  p_capture_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == LO_OFS) |=> shadowNow == $past(cntNow[2*DATA_W-1 -: DATA_W]));

  p_hi_shadow_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == HI_OFS) |-> rdData == shadowNow);

  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> rdData == '0);
endmodule

bind coherentTimeCounter tcChecker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LO_OFS(LO_OFS), .HI_OFS(HI_OFS)
) uChk (
  .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .rdEn(rdEn),
  .addr(addr), .rdData(rdData), .uploadNow(uploadNow), .cntNow(cntNow),
  .stageNow(stageNow), .shadowNow(shadowNow)
);

// File: tb/sim_coherentTimeCounter.sv
`timescale 1ns/1ps
module sim_coherentTimeCounter;
  localparam logic [7:0] A_LO = 8'h20, A_HI = 8'h24, A_CTRL = 8'h28, A_BAD = 8'h2C;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;

  int nChecks = 0;
  int nErrors = 0;
  bit done = 1'b0;

  // Bench reference state
  logic [63:0] mCnt, mStage;
  logic [31:0] mShadow;
  logic        mUp;

  always #4 clk = ~clk;

  coherentTimeCounter u0 (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData)
  );

  function automatic logic [31:0] expRead(input logic [7:0] a);
    case (a)
      A_LO:    return mCnt[31:0];
      A_HI:    return mShadow;
      A_CTRL:  return {31'b0, mUp};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string reqOf(input logic [7:0] a);
    case (a)
      A_LO:    return "R7";
      A_HI:    return "R8";
      A_CTRL:  return "R5";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // One clock: drive at negedge, sample reads, then advance the model.
  task automatic step(input logic t, input logic w, input logic r,
                      input logic [7:0] a, input logic [31:0] d, input string req);
    logic [63:0] nCnt;
    logic        nUp;
    @(negedge clk);
    tick = t; wrEn = w; rdEn = r; addr = a; wrData = d;
    #1;
    if (r) check(req.len() ? req : reqOf(a), rdData, expRead(a));
    else   check("R9", rdData, 32'h0);
    @(posedge clk);
    nCnt = mUp ? mStage : (t ? mCnt + 64'd1 : mCnt);
    nUp  = w && (a == A_CTRL) && d[0];
    if (w && a == A_LO) mStage[31:0]  = d;
    if (w && a == A_HI) mStage[63:32] = d;
    if (r && a == A_LO) mShadow = mCnt[63:32];
    mCnt = nCnt;
    mUp  = nUp;
  endtask

  task automatic idle(input logic t);
    step(t, 1'b0, 1'b0, 8'h0, 32'h0, "");
  endtask

  task automatic load64(input logic [63:0] v);
    step(1'b0, 1'b1, 1'b0, A_LO, v[31:0], "");
    step(1'b0, 1'b1, 1'b0, A_HI, v[63:32], "");
    step(1'b0, 1'b1, 1'b0, A_CTRL, 32'h1, "");
    step(1'b0, 1'b0, 1'b1, A_CTRL, 32'h0, "R5");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nErrors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    mCnt = '0; mStage = '0; mShadow = '0; mUp = 1'b0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1 / R8: reset values, high word read with no prior low read
    step(1'b0, 1'b0, 1'b1, A_HI, 0, "R1");
    step(1'b0, 1'b0, 1'b1, A_LO, 0, "R1");
    step(1'b0, 1'b0, 1'b1, A_CTRL, 0, "R1");
    step(1'b0, 1'b0, 1'b1, A_HI, 0, "R8");

    // R2: ticks counted, idle cycles hold
    for (int i = 0; i < 5; i++) idle(1'b1);
    for (int i = 0; i < 3; i++) idle(1'b0);
    step(1'b0, 1'b0, 1'b1, A_LO, 0, "R2");

    // R4: staging writes leave the counter alone
    step(1'b1, 1'b1, 1'b0, A_LO, 32'hDEAD_BEEF, "");
    step(1'b0, 1'b1, 1'b0, A_HI, 32'h1234_5678, "");
    step(1'b0, 1'b0, 1'b1, A_LO, 0, "R4");

    // R5: upload, self clear, full 64-bit transfer
    load64(64'h0000_0001_FFFF_FFF0);
    step(1'b0, 1'b0, 1'b1, A_CTRL, 0, "R5");
    step(1'b0, 1'b0, 1'b1, A_LO, 0, "R5");
    step(1'b0, 1'b0, 1'b1, A_HI, 0, "R5");

    // R8: shadow holds while low word carries into the high word
    step(1'b0, 1'b0, 1'b1, A_LO, 0, "R7");
    for (int i = 0; i < 20; i++) idle(1'b1);
    step(1'b0, 1'b0, 1'b1, A_HI, 0, "R8");
    step(1'b0, 1'b0, 1'b1, A_LO, 0, "R7");
    step(1'b0, 1'b0, 1'b1, A_HI, 0, "R8");

    // R6: upload and tick in the same cycle
    step(1'b0, 1'b1, 1'b0, A_LO, 32'h0000_0100, "");
    step(1'b0, 1'b1, 1'b0, A_HI, 32'h0, "");
    step(1'b0, 1'b1, 1'b0, A_CTRL, 32'h1, "");
    idle(1'b1);
    step(1'b0, 1'b0, 1'b1, A_LO, 0, "R6");
    check("R6", rdData, 32'h0000_0100);

    // R3: wrap from all ones
    load64(64'hFFFF_FFFF_FFFF_FFFE);
    idle(1'b1);
    idle(1'b1);
    step(1'b0, 1'b0, 1'b1, A_LO, 0, "R3");
    step(1'b0, 1'b0, 1'b1, A_HI, 0, "R3");
    check("R3", rdData, 32'h0);

    // R9: unmapped offset and writes of 0 to control
    step(1'b0, 1'b1, 1'b0, A_BAD, 32'hFFFF_FFFF, "");
    step(1'b0, 1'b1, 1'b0, A_CTRL, 32'h0, "");
    step(1'b0, 1'b0, 1'b1, A_BAD, 0, "R9");
    step(1'b0, 1'b0, 1'b1, A_LO, 0, "R9");

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      int op;
      logic t;
      op = $urandom_range(0, 11);
      t  = (i < 2000) ? ($urandom_range(0, 3) != 0) : ($urandom_range(0, 7) == 0);
      case (op)
        0, 1, 2: step(t, 1'b0, 1'b1, A_LO, 0, "");
        3, 4:    step(t, 1'b0, 1'b1, A_HI, 0, "");
        5:       step(t, 1'b0, 1'b1, A_CTRL, 0, "");
        6:       step(t, 1'b0, 1'b1, A_BAD, 0, "");
        7:       step(t, 1'b1, 1'b0, A_LO, $urandom(), "");
        8:       step(t, 1'b1, 1'b0, A_HI, ($urandom_range(0, 1) != 0) ? 32'hFFFF_FFFF : $urandom(), "");
        9:       step(t, 1'b1, 1'b0, A_CTRL, $urandom_range(0, 3), "");
        10:      step(t, 1'b1, 1'b0, A_BAD, $urandom(), "");
        default: idle(t);
      endcase
    end
    step(1'b0, 1'b0, 1'b1, A_LO, 0, "R2");
    step(1'b0, 1'b0, 1'b1, A_HI, 0, "R8");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end
endmodule